// File: doc/BRIEF.md
# Single-Cycle Integer Core (Add, Add-Immediate, Or-Immediate, Store)

This block is a 32-bit integer core that completes one instruction in each clock cycle. A 32-bit instruction word arrives on an input port and is decoded in the same cycle. The core reads two operands from a 32-entry register file, computes a result in a small ALU and, on the next rising edge, either writes that result back to a register or stores a register value into a small internal word memory. The core has no fetch logic. The environment supplies the instruction stream directly. It watches the ALU result, the store data and the store strobe to follow execution.

The ALU's second operand comes from a four-way operand selector. The selector chooses among the second register read, the immediate extended with its sign, and the immediate padded with sixteen zero bits. The fourth select code yields zero. Padding with zeros is what lets the or-immediate instruction combine a register with a 16-bit constant without smearing bit 15 into the upper half.

The decoder sorts each word into one of five instruction classes: ADDI, ADD, STORE, ORI and NONE. From that class it derives the write enable, the destination choice, the operand select, the ALU operation and the store strobe. Any word that falls in class NONE leaves all state untouched.

Top module: `core_top`

## Requirements
- R1: While `rst` is high at a rising edge, every register clears to zero; after reset, reading any register index gives 0.
- R2: Opcode 001000 (add-immediate) makes `aluout` equal to register[bits 25:21] plus the 16-bit immediate (bits 15:0) sign-extended, and writes that sum to register[bits 20:16].
- R3: Opcode 000000 with function field (bits 5:0) 100000 makes `aluout` equal to register[bits 25:21] plus register[bits 20:16], and writes the sum to register[bits 15:11].
- R4: Opcode 101011 (store) raises `memwrite`, sets `aluout` to register[bits 25:21] plus the sign-extended immediate (the word address), and presents register[bits 20:16] on `writedata`.
- R5: Opcode 001101 (or-immediate) makes `aluout` equal to register[bits 25:21] OR the immediate with sixteen zero bits above it, and writes the result to register[bits 20:16]. An immediate with bit 15 set leaves bits 31:16 of the operand zero.
- R6: Register 0 always reads as zero, and any write aimed at it is discarded.
- R7: A register write takes effect at the rising edge that ends the instruction's cycle. During that cycle, reads of the target still return the old value.
- R8: `memwrite` is high only while a store word is presented, and low for every other instruction.
- R9: A word whose opcode is none of the four above, or an opcode-000000 word whose function field is not 100000, changes no register and keeps `memwrite` low.
- R10: A store writes no register; its register[bits 20:16] source keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the register file |
| instr | input | 32 | Instruction word executed in the current cycle |
| aluout | output | 32 | ALU result: written-back value, or store address |
| writedata | output | 32 | Value read from register[bits 20:16]; the store data |
| memwrite | output | 1 | High while the current word is a store |

## Verification
The bound checker compares the ALU result against the register-file read ports on every cycle for each instruction class. It also checks that the store strobe tracks the store opcode and that class NONE and store words never raise the register write enable. The register-0 read rule and the all-zero read after reset are checked on every cycle as well. Only the bench scenarios can show that values survive across edges: the write landing at the edge and not before, the reset clearing all 32 entries, discarded writes to register 0, and registers left intact after store and unsupported words. These need a value written in one cycle to be read back in a later one.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam int INSTR_W = 32;
    localparam int IMM_W   = 16;
    localparam int RIDX_W  = 5;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_ADDI  = 6'b001000;
    localparam logic [5:0] OP_ORI   = 6'b001101;
    localparam logic [5:0] OP_SW    = 6'b101011;
    localparam logic [5:0] FN_ADD   = 6'b100000;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_ADDI = 3'd1,
        K_ADD  = 3'd2,
        K_SW   = 3'd3,
        K_ORI  = 3'd4
    } ikind_t;

    typedef enum logic [1:0] {
        B_REG  = 2'b00,
        B_SEXT = 2'b01,
        B_ZEXT = 2'b10,
        B_ZERO = 2'b11
    } bsel_t;

    typedef enum logic {
        A_ADD = 1'b0,
        A_OR  = 1'b1
    } aluop_t;

    typedef struct packed {
        logic   rf_we;
        logic   dst_rd;
        bsel_t  bsel;
        aluop_t aluop;
        logic   mem_we;
    } ctrl_t;

endpackage

// File: rtl/core_decode.sv
module core_decode
    import core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ikind_t     kind,
    output ctrl_t      ctl
);

    // classify the word
    always_comb begin
        kind = K_NONE;
        unique case (opcode)
            OP_RTYPE: kind = (funct == FN_ADD) ? K_ADD : K_NONE;
            OP_ADDI:  kind = K_ADDI;
            OP_ORI:   kind = K_ORI;
            OP_SW:    kind = K_SW;
            default:  kind = K_NONE;
        endcase
    end

    // control word per class
    always_comb begin
        ctl.rf_we  = 1'b0;
        ctl.dst_rd = 1'b0;
        ctl.bsel   = B_REG;
        ctl.aluop  = A_ADD;
        ctl.mem_we = 1'b0;
        unique case (kind)
            K_ADDI: begin
                ctl.rf_we = 1'b1;
                ctl.bsel  = B_SEXT;
            end
            K_ADD: begin
                ctl.rf_we  = 1'b1;
                ctl.dst_rd = 1'b1;
                ctl.bsel   = B_REG;
            end
            K_SW: begin
                ctl.bsel   = B_SEXT;
                ctl.mem_we = 1'b1;
            end
            K_ORI: begin
                ctl.rf_we = 1'b1;
                ctl.bsel  = B_ZEXT;
                ctl.aluop = A_OR;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/core_immext.sv
module core_immext #(
    parameter int IMM_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] sext,
    output logic [DATA_W-1:0] zext
);

    localparam int PAD_W = DATA_W - IMM_W;

    assign sext = {{PAD_W{imm[IMM_W-1]}}, imm};
    assign zext = {{PAD_W{1'b0}}, imm};

endmodule

// File: rtl/core_alu.sv
module core_alu
    import core_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] srca,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [DATA_W-1:0] imm_s,
    input  logic [DATA_W-1:0] imm_z,
    input  bsel_t             bsel,
    input  aluop_t            aluop,
    output logic [DATA_W-1:0] y
);

    logic [DATA_W-1:0] srcb;

    // four-way operand B selector; code 11 gives zero
    always_comb begin
        unique case (bsel)
            B_REG:   srcb = reg_b;
            B_SEXT:  srcb = imm_s;
            B_ZEXT:  srcb = imm_z;
            default: srcb = '0;
        endcase
    end

    always_comb begin
        unique case (aluop)
            A_OR:    y = srca | srcb;
            default: y = srca + srcb;
        endcase
    end

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
    parameter int DATA_W = 32,
    parameter int REGS   = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(REGS)-1:0] ra1,
    input  logic [$clog2(REGS)-1:0] ra2,
    input  logic                    we,
    input  logic [$clog2(REGS)-1:0] wa,
    input  logic [DATA_W-1:0]       wd,
    output logic [DATA_W-1:0]       rd1,
    output logic [DATA_W-1:0]       rd2
);

    logic [DATA_W-1:0] regs [REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REGS; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/core_dmem.sv
module core_dmem #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 64
) (
    input  logic              clk,
    input  logic              we,
    input  logic [DATA_W-1:0] addr,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] q
);

    localparam int AW = $clog2(WORDS);

    logic [DATA_W-1:0] words [WORDS];
    logic [AW-1:0]     idx;
    logic              addr_unused;

    assign idx         = addr[AW+1:2];
    assign addr_unused = ^{addr[DATA_W-1:AW+2], addr[1:0]};

    always_ff @(posedge clk) begin
        if (we) begin
            words[idx] <= wd;
        end
    end

    assign q = words[idx];

endmodule

// File: rtl/core_top.sv
module core_top
    import core_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       instr,
    output logic [DATA_W-1:0] aluout,
    output logic [DATA_W-1:0] writedata,
    output logic              memwrite
);

    localparam int REGS = 1 << RIDX_W;

    ikind_t             kind;
    ctrl_t              ctl;
    logic [RIDX_W-1:0]  f_rs, f_rt, f_rd, waddr;
    logic [IMM_W-1:0]   f_imm;
    logic [DATA_W-1:0]  rs_val, rt_val, imm_s, imm_z;
    logic               rf_we;
    logic [DATA_W-1:0]  mem_q_unused;
    logic               kind_unused;

    assign f_rs  = instr[25:21];
    assign f_rt  = instr[20:16];
    assign f_rd  = instr[15:11];
    assign f_imm = instr[15:0];

    core_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .kind   (kind),
        .ctl    (ctl)
    );

    assign kind_unused = ^kind;
    assign rf_we       = ctl.rf_we;
    assign waddr       = ctl.dst_rd ? f_rd : f_rt;

    core_immext #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_ext (
        .imm  (f_imm),
        .sext (imm_s),
        .zext (imm_z)
    );

    core_regfile #(.DATA_W(DATA_W), .REGS(REGS)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (f_rs),
        .ra2 (f_rt),
        .we  (rf_we),
        .wa  (waddr),
        .wd  (aluout),
        .rd1 (rs_val),
        .rd2 (rt_val)
    );

    core_alu #(.DATA_W(DATA_W)) u_alu (
        .srca  (rs_val),
        .reg_b (rt_val),
        .imm_s (imm_s),
        .imm_z (imm_z),
        .bsel  (ctl.bsel),
        .aluop (ctl.aluop),
        .y     (aluout)
    );

    core_dmem #(.DATA_W(DATA_W), .WORDS(MEM_WORDS)) u_mem (
        .clk  (clk),
        .we   (ctl.mem_we),
        .addr (aluout),
        .wd   (rt_val),
        .q    (mem_q_unused)
    );

    assign writedata = rt_val;
    assign memwrite  = ctl.mem_we;

endmodule

// File: rtl/core_chk.sv
module core_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [31:0]       instr,
    input logic [DATA_W-1:0] aluout,
    input logic [DATA_W-1:0] writedata,
    input logic              memwrite,
    input logic [DATA_W-1:0] rs_val,
    input logic [DATA_W-1:0] rt_val,
    input logic              rf_we
);

    logic [5:0]        op, fn;
    logic              is_addi, is_add, is_sw, is_ori, known;
    logic [DATA_W-1:0] sx, zx;

    assign op      = instr[31:26];
    assign fn      = instr[5:0];
    assign is_addi = (op == 6'b001000);
    assign is_ori  = (op == 6'b001101);
    assign is_sw   = (op == 6'b101011);
    assign is_add  = (op == 6'b000000) && (fn == 6'b100000);
    assign known   = is_addi | is_ori | is_sw | is_add;
    assign sx      = {{(DATA_W-16){instr[15]}}, instr[15:0]};
    assign zx      = {{(DATA_W-16){1'b0}}, instr[15:0]};

    p_rst_clears_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rs_val == '0 && rt_val == '0));

    p_addi_sum_r2: assert property (@(posedge clk) disable iff (rst)
        is_addi |-> (aluout == rs_val + sx) && rf_we);

    p_add_sum_r3: assert property (@(posedge clk) disable iff (rst)
        is_add |-> (aluout == rs_val + rt_val) && rf_we);

    p_store_out_r4: assert property (@(posedge clk) disable iff (rst)
        is_sw |-> (aluout == rs_val + sx) && (writedata == rt_val));

    p_ori_zext_r5: assert property (@(posedge clk) disable iff (rst)
        is_ori |-> (aluout == (rs_val | zx)) && rf_we);

    p_zero_reg_r6: assert property (@(posedge clk) disable iff (rst)
        (instr[25:21] == 5'd0) |-> (rs_val == '0));

    p_strobe_sw_r8: assert property (@(posedge clk) disable iff (rst)
        memwrite == is_sw);

    p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !known |-> (!memwrite && !rf_we));

    p_store_nowb_r10: assert property (@(posedge clk) disable iff (rst)
        is_sw |-> !rf_we);

endmodule

bind core_top core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .instr     (instr),
    .aluout    (aluout),
    .writedata (writedata),
    .memwrite  (memwrite),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .rf_we     (rf_we)
);

// File: tb/core_top_test.sv
`timescale 1ns/1ps
module core_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = 32'h0;
    logic [31:0] aluout, writedata;
    logic        memwrite;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    core_top uut (
        .clk       (clk),
        .rst       (rst),
        .instr     (instr),
        .aluout    (aluout),
        .writedata (writedata),
        .memwrite  (memwrite)
    );

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'd0, fn};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // present a word at the falling edge; it retires at the next rising edge
    task automatic issue(logic [31:0] w);
        @(negedge clk);
        instr = w;
        #1;
    endtask

    // read a register through the store path (store data = rt)
    task automatic peek(logic [4:0] r, output logic [31:0] v);
        issue(enc_i(6'b101011, 5'd0, r, 16'h0040));
        v = writedata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst   = 1'b1;
        instr = 32'h0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        issue(enc_i(6'b001000, 5'd0, 5'd5, 16'h1234));
        issue(enc_i(6'b001000, 5'd0, 5'd31, 16'hFFFF));
        issue(enc_i(6'b001000, 5'd0, 5'd16, 16'h0003));
        do_reset();
        for (int r = 0; r < 32; r++) begin
            peek(r[4:0], v);
            chk("R1", $sformatf("reg%0d after reset", r), v, 32'h0);
        end
        chk("R8", "memwrite on store probe", {31'd0, memwrite}, 32'd1);
    endtask

    task automatic t_program();
        issue(32'h2010002C);
        chk("R2", "addi 44 aluout", aluout, 32'h0000002C);
        chk("R8", "addi memwrite", {31'd0, memwrite}, 32'd0);
        issue(32'h2011FFDB);
        chk("R2", "addi -37 aluout", aluout, 32'hFFFFFFDB);
        issue(32'h02119020);
        chk("R3", "add aluout", aluout, 32'h00000007);
        chk("R8", "add memwrite", {31'd0, memwrite}, 32'd0);
        issue(32'hAC120054);
        chk("R4", "store address", aluout, 32'h00000054);
        chk("R4", "store data", writedata, 32'h00000007);
        chk("R4", "store strobe", {31'd0, memwrite}, 32'd1);
        // negative offset from a nonzero base
        issue(enc_i(6'b101011, 5'd16, 5'd17, 16'hFFFC));
        chk("R4", "store addr base-4", aluout, 32'h00000028);
        chk("R4", "store data -37", writedata, 32'hFFFFFFDB);
    endtask

    task automatic t_ori();
        logic [31:0] v;
        issue(32'h36538000);
        chk("R5", "ori 7|8000", aluout, 32'h00008007);
        chk("R8", "ori memwrite", {31'd0, memwrite}, 32'd0);
        issue(enc_i(6'b001101, 5'd0, 5'd10, 16'hFFFF));
        chk("R5", "ori zero-extend FFFF", aluout, 32'h0000FFFF);
        peek(5'd10, v);
        chk("R5", "ori result stored", v, 32'h0000FFFF);
        peek(5'd19, v);
        chk("R5", "ori result in reg19", v, 32'h00008007);
    endtask

    task automatic t_unsupported();
        logic [31:0] v;
        issue(32'h8C130000);
        chk("R9", "load-op memwrite", {31'd0, memwrite}, 32'd0);
        issue(32'h02119822);
        chk("R9", "sub-funct memwrite", {31'd0, memwrite}, 32'd0);
        issue(enc_i(6'b000100, 5'd16, 5'd19, 16'h0001));
        peek(5'd19, v);
        chk("R9", "reg19 untouched", v, 32'h00008007);
    endtask

    task automatic t_store_nowb();
        logic [31:0] v;
        issue(enc_i(6'b101011, 5'd0, 5'd18, 16'h0054));
        issue(enc_i(6'b101011, 5'd17, 5'd16, 16'h0100));
        peek(5'd18, v);
        chk("R10", "reg18 after store", v, 32'h00000007);
        peek(5'd16, v);
        chk("R10", "reg16 after store", v, 32'h0000002C);
    endtask

    task automatic t_reg0();
        logic [31:0] v;
        issue(enc_i(6'b001000, 5'd0, 5'd0, 16'h0005));
        issue(enc_r(5'd16, 5'd17, 5'd0, 6'b100000));
        peek(5'd0, v);
        chk("R6", "reg0 after writes", v, 32'h0);
        issue(enc_r(5'd0, 5'd0, 5'd11, 6'b100000));
        chk("R6", "reg0+reg0", aluout, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        issue(enc_i(6'b001000, 5'd0, 5'd9, 16'h0009));
        chk("R7", "target old value in cycle", writedata, 32'h0);
        chk("R7", "addi 9 aluout", aluout, 32'h9);
        issue(enc_i(6'b001000, 5'd9, 5'd9, 16'h0001));
        chk("R7", "new value next cycle", aluout, 32'hA);
        chk("R7", "rt still 9 in cycle", writedata, 32'h9);
        peek(5'd9, v);
        chk("R7", "after second edge", v, 32'hA);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_program();
        t_ori();
        t_unsupported();
        t_store_nowb();
        t_reg0();
        t_edge();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule